// File: doc/BRIEF.md
# Accumulator Fetch-Decode-Execute Core

This block is a tiny single-accumulator processor. Program words and data words share one 32-entry memory of 8-bit words. A phase sequencer moves every instruction through a fixed chain of one-cycle register transfers. The chain uses a program counter, a memory address register, a memory data register, an instruction register and the accumulator. No step fetches directly from memory into the decoder. The core runs until it executes a halt, then freezes and raises a flag.

The memory sits inside the block. It is filled through a valid/ready load port that only accepts words while reset is held. `load_ready` equals `rst`. A word is written when `load_valid` and `load_ready` are both high in the same cycle. A producer that sees `load_ready` low must hold its word until reset is asserted again. Outside reset the port applies back-pressure for as long as the core runs.

A debug port shows the program counter, the accumulator and the current phase so that execution can be followed cycle by cycle.

Top module: `acc_fde_core`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `dbg_pc`=0, `dbg_acc`=0, `halted`=0 and `dbg_phase`=0. The internal address, data and instruction registers also clear.
- R2: `load_ready` is high exactly while `rst` is high. A word presented with `load_valid` and `load_ready` both high is written to `load_addr`. A word presented while `load_ready` is low is ignored and leaves memory unchanged.
- R3: An instruction word carries its operation in bits [7:5] and a memory address in bits [4:0]. The operation codes are: 0 load, 1 store, 2 add, 3 subtract, 4 AND, 5 jump, 6 jump-if-accumulator-zero, 7 halt.
- R4: The phase codes are 0 address-from-PC, 1 PC-increment/read, 2 capture word, 3 copy to instruction register, 4 decode, 5 operand read, 6 operand capture, 7 execute and 8 halted. A load, store, add, subtract or AND instruction passes through phases 0 to 7 in order, one cycle each, and then returns to phase 0.
- R5: The program counter rises by one (modulo 32) when phase 1 ends, so `dbg_pc` already shows the next address from phase 2 onward.
- R6: Load, add, subtract and AND change the accumulator only when phase 7 ends. Add and subtract wrap modulo 256. The accumulator stays unchanged in every other phase.
- R7: A store writes the accumulator to its address when phase 7 ends. A later load from that address returns the stored value.
- R8: A jump loads its address into the program counter when decode ends, skips phases 5 to 7 and goes back to phase 0.
- R9: Jump-if-zero acts like R8 when the accumulator is 0. Otherwise it leaves the incremented program counter in place and returns to phase 0 after decode.
- R10: A halt sets `halted` and `dbg_phase`=8 when decode ends. From then until reset, the program counter, accumulator, phase and memory do not change.
- R11: Program and data live in the same memory. A word written by a store is fetched and executed as an instruction if the program counter later reaches its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| load_valid | input | 1 | Load word present |
| load_ready | output | 1 | Load port accepts a word (high during reset) |
| load_addr | input | 5 | Memory address of the load word |
| load_data | input | 8 | Word to store in memory |
| halted | output | 1 | Core has executed a halt |
| dbg_pc | output | 5 | Program counter |
| dbg_acc | output | 8 | Accumulator |
| dbg_phase | output | 4 | Current phase code (see R4) |

## Verification
Three programs run against a per-cycle expected trace of phase, program counter, accumulator and halt flag.

The first program chains load, add, subtract and AND on operands chosen to wrap both upward and downward. This separates the correct modulo behaviour and operand order from a swapped or saturating operation.

The second program stores a halt word over the jump at the end of a loop. This can only stop if a store really lands in the shared memory and is fetched again as code.

The third program takes jump-if-zero once and skips it once, then jumps unconditionally. During this run it keeps a load word presented, which would break the program if the port did not ignore it outside reset.

// File: rtl/acc_fde_pkg.sv
package acc_fde_pkg;

  typedef enum logic [3:0] {
    PH_FMAR = 4'd0,
    PH_FINC = 4'd1,
    PH_FMDR = 4'd2,
    PH_FCIR = 4'd3,
    PH_DEC  = 4'd4,
    PH_ORD  = 4'd5,
    PH_OMDR = 4'd6,
    PH_EXEC = 4'd7,
    PH_HALT = 4'd8
  } phase_e;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_AND   = 3'd4,
    OP_JMP   = 3'd5,
    OP_JZ    = 3'd6,
    OP_HALT  = 3'd7
  } opcode_e;

  localparam int OPC_W = 3;

endpackage

// File: rtl/acc_fde_mem.sv
module acc_fde_mem #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store_q [DEPTH];

  // one write port, one registered read port (one cycle of latency)
  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
    rdata <= store_q[raddr];
  end
endmodule

// File: rtl/acc_fde_seq.sv
module acc_fde_seq
  import acc_fde_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e op,
  output phase_e  phase,
  output logic    halted
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_FMAR: phase_d = PH_FINC;
      PH_FINC: phase_d = PH_FMDR;
      PH_FMDR: phase_d = PH_FCIR;
      PH_FCIR: phase_d = PH_DEC;
      PH_DEC: begin
        if (op == OP_HALT)                   phase_d = PH_HALT;
        else if (op == OP_JMP || op == OP_JZ) phase_d = PH_FMAR;
        else                                  phase_d = PH_ORD;
      end
      PH_ORD:  phase_d = PH_OMDR;
      PH_OMDR: phase_d = PH_EXEC;
      PH_EXEC: phase_d = PH_FMAR;
      PH_HALT: phase_d = PH_HALT;
      default: phase_d = PH_FMAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FMAR;
      halted <= 1'b0;
    end else begin
      phase <= phase_d;
      if (phase == PH_DEC && op == OP_HALT) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_fde_dp.sv
module acc_fde_dp
  import acc_fde_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  opcode_e           op,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] mdr,
  output logic [WORD_W-1:0] cir,
  output logic [WORD_W-1:0] acc
);
  logic [ADDR_W-1:0] cir_addr;
  logic              acc_zero;
  logic              take_jump;

  assign cir_addr  = cir[ADDR_W-1:0];
  assign acc_zero  = (acc == '0);
  assign take_jump = (op == OP_JMP) || (op == OP_JZ && acc_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      unique case (phase)
        PH_FMAR: mar <= pc;
        PH_FINC: pc  <= pc + ADDR_W'(1);
        PH_FMDR: mdr <= mem_rdata;
        PH_FCIR: cir <= mdr;
        PH_DEC: begin
          if (take_jump) pc <= cir_addr;
          else if (op != OP_JMP && op != OP_JZ && op != OP_HALT) mar <= cir_addr;
        end
        PH_ORD: ;
        PH_OMDR: mdr <= (op == OP_STORE) ? acc : mem_rdata;
        PH_EXEC: begin
          unique case (op)
            OP_LOAD: acc <= mdr;
            OP_ADD:  acc <= acc + mdr;
            OP_SUB:  acc <= acc - mdr;
            OP_AND:  acc <= acc & mdr;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_fde_core.sv
module acc_fde_core
  import acc_fde_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [WORD_W-1:0] dbg_acc,
  output logic [3:0]        dbg_phase
);
  phase_e            phase_q;
  opcode_e           op;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] mdr_q, cir_q, acc_q, mem_rdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;

  assign op = opcode_e'(cir_q[WORD_W-1 -: OPC_W]);

  // load port owns the write path in reset; the store path owns it afterwards
  assign load_ready = rst;
  assign mem_we    = rst ? load_valid : (phase_q == PH_EXEC && op == OP_STORE);
  assign mem_waddr = rst ? load_addr  : mar_q;
  assign mem_wdata = rst ? load_data  : mdr_q;

  acc_fde_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar_q),
    .rdata (mem_rdata)
  );

  acc_fde_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .phase  (phase_q),
    .halted (halted)
  );

  acc_fde_dp #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase_q),
    .op        (op),
    .mem_rdata (mem_rdata),
    .pc        (pc_q),
    .mar       (mar_q),
    .mdr       (mdr_q),
    .cir       (cir_q),
    .acc       (acc_q)
  );

  assign dbg_pc    = pc_q;
  assign dbg_acc   = acc_q;
  assign dbg_phase = phase_q;
endmodule

// File: rtl/acc_fde_chk.sv
module acc_fde_chk
  import acc_fde_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input phase_e            phase,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] cir,
  input logic              halted
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && phase == PH_FMAR && !halted));

  assert_fetch_step_R4: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FMAR |=> phase == PH_FINC);

  assert_exec_return_R4: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EXEC |=> phase == PH_FMAR);

  assert_pc_inc_R5: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FINC |=> pc == $past(pc) + ADDR_W'(1));

  assert_acc_exec_only_R6: assert property (@(posedge clk) disable iff (rst)
    phase != PH_EXEC |=> $stable(acc));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DEC && cir[WORD_W-1 -: OPC_W] == OP_JMP)
      |=> (pc == $past(cir[ADDR_W-1:0]) && phase == PH_FMAR));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && phase == PH_HALT && $stable(pc) && $stable(acc)));
endmodule

bind acc_fde_core acc_fde_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .phase  (phase_q),
  .pc     (pc_q),
  .acc    (acc_q),
  .cir    (cir_q),
  .halted (halted)
);

// File: tb/acc_fde_core_bench.sv
module acc_fde_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_valid = 1'b0;
  logic       load_ready;
  logic [4:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic       halted;
  logic [4:0] dbg_pc;
  logic [7:0] dbg_acc;
  logic [3:0] dbg_phase;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [7:0] img [32];

  int q_ph[$], q_pc[$], q_acc[$], q_hlt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_fde_core u_acc_fde_core (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_phase(dbg_phase)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: act %0d cycles exp fewer than 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int ph, input int pc, input int acc, input int h);
    q_ph.push_back(ph); q_pc.push_back(pc); q_acc.push_back(acc); q_hlt.push_back(h);
  endtask

  // instruction-level behavioural model expanded into a per-cycle trace
  task automatic build_trace(input int ncyc);
    int m[32];
    int pc = 0, acc = 0, h = 0;
    for (int i = 0; i < 32; i++) m[i] = img[i];
    q_ph.delete(); q_pc.delete(); q_acc.delete(); q_hlt.delete();
    while (q_ph.size() < ncyc) begin
      if (h != 0) begin
        push(8, pc, acc, 1);
      end else begin
        int w = m[pc];
        int op = w >> 5;
        int a = w & 31;
        int npc = (pc + 1) % 32;
        push(0, pc, acc, 0);
        push(1, pc, acc, 0);
        push(2, npc, acc, 0);
        push(3, npc, acc, 0);
        push(4, npc, acc, 0);
        pc = npc;
        if (op == 5) pc = a;
        else if (op == 6) begin if (acc == 0) pc = a; end
        else if (op == 7) h = 1;
        else begin
          push(5, pc, acc, 0);
          push(6, pc, acc, 0);
          push(7, pc, acc, 0);
          case (op)
            0: acc = m[a];
            1: m[a] = acc;
            2: acc = (acc + m[a]) % 256;
            3: acc = (acc - m[a] + 256) % 256;
            default: acc = acc & m[a];
          endcase
        end
      end
    end
  endtask

  task automatic run_prog(input string tag, input int ncyc, input bit poke);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      load_valid = 1'b1; load_addr = 5'(i); load_data = img[i];
      @(negedge clk);
      if (i == 0) check({tag, " R2 load_ready in reset"}, load_ready, 1);
    end
    load_valid = 1'b0;
    // R1: state after reset edges
    check({tag, " R1 pc"}, dbg_pc, 0);
    check({tag, " R1 acc"}, dbg_acc, 0);
    check({tag, " R1 phase"}, dbg_phase, 0);
    check({tag, " R1 halted"}, halted, 0);
    build_trace(ncyc);
    rst = 1'b0;
    if (poke) begin
      // R2: word offered outside reset must be ignored (would turn HALT at 9 into LOAD 0)
      load_valid = 1'b1; load_addr = 5'd9; load_data = 8'h00;
    end
    for (int i = 0; i < ncyc; i++) begin
      if (i > 0) @(negedge clk);
      if (poke && i == 3) check({tag, " R2 load_ready low"}, load_ready, 0);
      check({tag, " R4 phase"}, dbg_phase, q_ph[i]);
      check({tag, " R5 pc"}, dbg_pc, q_pc[i]);
      check({tag, " R6 acc"}, dbg_acc, q_acc[i]);
      check({tag, " R10 halted"}, halted, q_hlt[i]);
    end
    load_valid = 1'b0;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 32; i++) img[i] = 8'h00;
  endtask

  initial begin
    // P1 (R3, R4, R6): load F0, add 20 -> 10 (wrap), sub 30 -> E0 (wrap), and 6C -> 60, halt
    clear_img();
    img[0] = 8'h14; img[1] = 8'h55; img[2] = 8'h76; img[3] = 8'h97; img[4] = 8'hE0;
    img[20] = 8'hF0; img[21] = 8'h20; img[22] = 8'h30; img[23] = 8'h6C;
    run_prog("P1 alu", 50, 1'b0);
    check("P1 R6 final acc", dbg_acc, 8'h60);

    // P2 (R7, R11): store a halt word over the loop-back jump at 3
    clear_img();
    img[0] = 8'h14; img[1] = 8'h23; img[2] = 8'h15; img[3] = 8'hA0;
    img[20] = 8'hE0; img[21] = 8'h5A;
    run_prog("P2 store R7 R11", 40, 1'b0);
    check("P2 R11 halted by stored word", halted, 1);
    check("P2 R7 acc", dbg_acc, 8'h5A);

    // P3 (R8, R9, R2): JZ taken, JZ not taken, JMP, with a load word held during the run
    clear_img();
    img[0] = 8'h14; img[1] = 8'hC4; img[2] = 8'hE0; img[3] = 8'hE0;
    img[4] = 8'h15; img[5] = 8'hC2; img[6] = 8'hA8; img[7] = 8'hE0;
    img[8] = 8'h55; img[9] = 8'hE0;
    img[20] = 8'h00; img[21] = 8'h07;
    run_prog("P3 jumps R8 R9", 60, 1'b1);
    check("P3 R9 acc", dbg_acc, 14);
    check("P3 R10 pc frozen", dbg_pc, 10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule